// File: doc/BRIEF.md
# CPU-Cycle Interrupt Timer

This block is a cartridge-side interrupt timer clocked by the CPU's M2 cycle. Software loads a 16-bit terminal value one byte at a time. Writing the low byte clears the running count and starts the timer. The count then rises by one on every M2 cycle. When it reaches the terminal value, the active-low interrupt line goes low and the count freezes. The line stays low until software acknowledges it.

All three registers share the cartridge write decode. A register write is a cycle in which the write strobe is high and A15 is high. Address bits A3..A0 then pick the register: 13 acknowledges, 14 is the upper byte of the terminal value, and 15 is the lower byte. Any other write is ignored.

Reset is asserted asynchronously and released synchronously, two M2 edges after the reset input rises.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset, `irq_n` is high and the timer is idle. With no write, `irq_n` stays high indefinitely.
- R2: A write with `reg_sel`=14 stores `wr_data` as bits 15..8 of the terminal value T.
- R3: A write with `reg_sel`=15 stores `wr_data` as bits 7..0 of T. The same write clears the running count to zero and starts counting.
- R4: Let the write of R3 occur on rising edge e0. `irq_n` is low after edge e0+T+1 and high after every earlier edge. With T=0, it is low after edge e0+1.
- R5: Once `irq_n` is low, it stays low and the count stays frozen until an acknowledge write.
- R6: A write with `reg_sel`=13 releases `irq_n` at the same edge and stops counting. `irq_n` then stays high until the timer is started again.
- R7: A write of the upper byte while counting changes T but neither restarts nor stops the count. The interrupt fires when the continuing count reaches the new T.
- R8: Writes with `a15` low, or with `reg_sel` from 0 to 12, have no effect.
- R9: A low-byte write while counting restarts the count from zero with the new T.
- R10: An acknowledge write on the edge at which the count would match leaves `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m2_clk | input | 1 | CPU M2 cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| a15 | input | 1 | CPU address bit 15 |
| reg_sel | input | 4 | CPU address bits 3..0 |
| wr_data | input | 8 | CPU write data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two kinds of internal fault show up at `irq_n`. A wrong count, or a wrong terminal byte, moves the falling edge of `irq_n` away from cycle T+1 after the start write. That error is visible within one cycle of the expected edge. A lost running flag or a lost pending flag shows up as one of two things: an interrupt that never arrives, or an interrupt that releases without an acknowledge. The bench runs a behavioural model alongside the design and compares `irq_n` with it on every cycle. It also makes explicit checks at the exact cycle each requirement predicts.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int unsigned REG_ADDR_W = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned TERM_W     = 16;
  localparam int unsigned OFF_ACK    = 13;
  localparam int unsigned OFF_LOW    = 15;  // lane i sits at OFF_LOW - i
  localparam int unsigned LANES      = TERM_W / BYTE_W;
endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode
  import cyc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter int unsigned NLANE  = LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              a15,
  input  logic [ADDR_W-1:0] reg_sel,
  output logic [NLANE-1:0]  lane_we,
  output logic              ack_we,
  output logic              arm
);
  logic sel_ok;
  assign sel_ok = wr_en & a15;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int unsigned OFF = OFF_LOW - i;
    assign lane_we[i] = sel_ok & (reg_sel == OFF[ADDR_W-1:0]);
  end

  assign ack_we = sel_ok & (reg_sel == OFF_ACK[ADDR_W-1:0]);
  assign arm    = lane_we[0];

  // R8: at most one register strobe per cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lane_we, ack_we}));
endmodule

// File: rtl/cyc_irq_term.sv
module cyc_irq_term
  import cyc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned NLANE  = LANES,
  localparam int unsigned W     = DATA_W * NLANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANE-1:0]  lane_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [W-1:0]      term
);
  for (genvar i = 0; i < NLANE; i++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (lane_we[i]) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q <= '0;
      else if (lane_we[i]) byte_q <= byte_d;
    end

    assign term[i*DATA_W +: DATA_W] = byte_q;

    // R2/R3: a written lane holds the written byte
    a_r2_lane_store: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[i] |=> byte_q == $past(wr_data));
  end
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ack,
  input  logic [CNT_W-1:0] term,
  output logic             hit,
  output logic             running
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             run_q, run_d;
  logic             at_term;
  logic             cnt_en;

  assign at_term = (count_q == term);
  assign hit     = run_q & at_term & ~arm & ~ack;
  assign running = run_q;

  always_comb begin
    count_d = count_q;
    run_d   = run_q;
    if (ack) begin
      run_d = 1'b0;
    end else if (arm) begin
      count_d = '0;
      run_d   = 1'b1;
    end else if (run_q) begin
      if (at_term) run_d   = 1'b0;
      else         count_d = count_q + 1'b1;
    end
  end

  assign cnt_en = ack | arm | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (cnt_en) begin
      count_q <= count_d;
      run_q   <= run_d;
    end
  end

  // R3: start write clears the count and runs
  a_r3_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !ack) |=> (count_q == '0) && run_q);
  // R5: count frozen while stopped
  a_r5_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !arm) |=> $stable(count_q));
  // R6: acknowledge stops counting
  a_r6_ack_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !run_q);
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  input  logic running,
  output logic pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (ack)      pend_d = 1'b0;
    else if (hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R5: pending survives until acknowledged
  a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);
  // R6: acknowledge releases the line
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pend_q);
  // R4: rises only after a match
  a_r4_set_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !hit) |=> !pend_q);
  // R5: a match stops the counter
  a_r5_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !running);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
(
  input  logic                  m2_clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  a15,
  input  logic [REG_ADDR_W-1:0] reg_sel,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic                  irq_n
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge m2_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [LANES-1:0]  lane_we;
  logic              ack_we;
  logic              arm;
  logic [TERM_W-1:0] term;
  logic              hit;
  logic              running;
  logic              pend;

  cyc_irq_decode #(.ADDR_W(REG_ADDR_W), .NLANE(LANES)) u_dec (
    .clk(m2_clk), .rst_n(rst_int_n), .wr_en(wr_en), .a15(a15),
    .reg_sel(reg_sel), .lane_we(lane_we), .ack_we(ack_we), .arm(arm));

  cyc_irq_term #(.DATA_W(BYTE_W), .NLANE(LANES)) u_term (
    .clk(m2_clk), .rst_n(rst_int_n), .lane_we(lane_we),
    .wr_data(wr_data), .term(term));

  cyc_irq_counter #(.CNT_W(TERM_W)) u_cnt (
    .clk(m2_clk), .rst_n(rst_int_n), .arm(arm), .ack(ack_we),
    .term(term), .hit(hit), .running(running));

  cyc_irq_flag u_flag (
    .clk(m2_clk), .rst_n(rst_int_n), .hit(hit), .ack(ack_we),
    .running(running), .pend(pend));

  assign irq_n = ~pend;

  // R1: line released while in reset
  a_r1_reset_released: assert property (@(posedge m2_clk)
    !rst_int_n |=> irq_n);
endmodule

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  logic       m2_clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       a15;
  logic [3:0] reg_sel;
  logic [7:0] wr_data;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #5 m2_clk = ~m2_clk;

  cyc_irq_timer u_cyc_irq_timer (
    .m2_clk(m2_clk), .rst_n(rst_n), .wr_en(wr_en), .a15(a15),
    .reg_sel(reg_sel), .wr_data(wr_data), .irq_n(irq_n));

  // behavioural reference model
  int  m_term, m_cnt;
  bit  m_run, m_pend;
  always @(posedge m2_clk) begin
    if (!rst_n) begin
      m_term = 0; m_cnt = 0; m_run = 0; m_pend = 0;
    end else begin
      bit is_wr;
      bit fire;
      is_wr = wr_en && a15;
      fire = m_run && (m_cnt == m_term);
      if (is_wr && reg_sel == 4'd13) begin
        m_pend = 0; m_run = 0;
      end else if (is_wr && reg_sel == 4'd15) begin
        m_term = (m_term & 32'hFF00) | wr_data;
        m_cnt = 0; m_run = 1;
      end else begin
        if (is_wr && reg_sel == 4'd14) m_term = (m_term & 32'h00FF) | (int'(wr_data) << 8);
        if (fire) begin
          m_pend = 1; m_run = 0;
        end else if (m_run) begin
          m_cnt = (m_cnt + 1) & 32'hFFFF;
        end
      end
    end
  end

  always @(negedge m2_clk) begin
    if (!done) begin
      n_cmp++;
      if (irq_n !== !m_pend) begin
        n_bad++;
        $display("FAIL %s model compare: irq_n=%b expected=%b at %0t", phase, irq_n, !m_pend, $time);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_n=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic wr(input logic hi, input logic [3:0] off, input logic [7:0] d);
    wr_en = 1'b1; a15 = hi; reg_sel = off; wr_data = d;
    @(negedge m2_clk);
    wr_en = 1'b0; a15 = 1'b0; reg_sel = '0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge m2_clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; a15 = 1'b0; reg_sel = '0; wr_data = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1: idle after reset
    phase = "R1";
    check("R1", irq_n, 1'b1);
    cyc(60);
    check("R1", irq_n, 1'b1);

    // R3/R4: T=5 (hi=0)
    phase = "R4";
    wr(1, 4'd14, 8'h00);
    wr(1, 4'd15, 8'h05);
    cyc(5);  check("R4", irq_n, 1'b1);
    cyc(1);  check("R4", irq_n, 1'b0);
    // R5: held
    phase = "R5";
    cyc(40); check("R5", irq_n, 1'b0);
    // R8: acknowledge with a15 low is ignored
    phase = "R8";
    wr(0, 4'd13, 8'h00); check("R8", irq_n, 1'b0);
    for (int k = 0; k < 13; k++) wr(1, 4'(k), 8'hFF);
    check("R8", irq_n, 1'b0);
    // R6: ack
    phase = "R6";
    wr(1, 4'd13, 8'h00); check("R6", irq_n, 1'b1);
    cyc(30); check("R6", irq_n, 1'b1);
    // R8: start with a15 low does nothing
    phase = "R8";
    wr(0, 4'd15, 8'h00);
    cyc(20); check("R8", irq_n, 1'b1);

    // R4: T=0
    phase = "R4";
    wr(1, 4'd15, 8'h00);
    check("R4", irq_n, 1'b1);
    cyc(1);  check("R4", irq_n, 1'b0);
    wr(1, 4'd13, 8'h00);

    // R2/R4: T=0x0123 uses upper byte
    phase = "R2";
    wr(1, 4'd14, 8'h01);
    wr(1, 4'd15, 8'h23);
    cyc(291); check("R2", irq_n, 1'b1);
    cyc(1);   check("R2", irq_n, 1'b0);
    wr(1, 4'd13, 8'h00);

    // R7: upper byte changed mid-count, T 100 -> 356
    phase = "R7";
    wr(1, 4'd14, 8'h00);
    wr(1, 4'd15, 8'd100);
    cyc(19);
    wr(1, 4'd14, 8'h01);   // count keeps going
    cyc(336); check("R7", irq_n, 1'b1);
    cyc(1);   check("R7", irq_n, 1'b0);
    wr(1, 4'd13, 8'h00);

    // R9: restart while counting with T=10 (hi=0)
    phase = "R9";
    wr(1, 4'd14, 8'h00);
    wr(1, 4'd15, 8'd50);
    cyc(29);
    wr(1, 4'd15, 8'd10);
    cyc(10); check("R9", irq_n, 1'b1);
    cyc(1);  check("R9", irq_n, 1'b0);
    wr(1, 4'd13, 8'h00);

    // R10: ack on the matching edge, T=3
    phase = "R10";
    wr(1, 4'd15, 8'd3);
    cyc(3);
    wr(1, 4'd13, 8'h00);
    check("R10", irq_n, 1'b1);
    cyc(20); check("R10", irq_n, 1'b1);

    // R1: reset mid-count releases and idles
    phase = "R1";
    wr(1, 4'd15, 8'd8);
    cyc(3);
    rst_n = 1'b0;
    cyc(2);
    check("R1", irq_n, 1'b1);
    rst_n = 1'b1;
    cyc(30); check("R1", irq_n, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule